// File: doc/BRIEF.md
# LLC Access-Rate Estimator and Prefetch Throttle

This block sits next to an L2 prefetcher and decides whether a pending prefetch request may go out to the last-level cache. Every LLC access (a demand miss or an issued prefetch) pulses `acc_vld` and presents the current value of a free-running cycle counter. The block subtracts the timestamp of the previous access to get the interval, then feeds it into a signed gauge counter. Each access adds the interval to the gauge and subtracts the current rate estimate. When the gauge pins at its top the rate estimate climbs by one, and when it pins at its bottom the rate estimate falls by one. The rate therefore settles near the mean number of cycles between LLC accesses. A small rate means heavy traffic.

From the rate and the best-offset score supplied by the prefetcher, the block derives an MSHR occupancy threshold. A confident score or sparse traffic allows a high threshold. Dense traffic pulls the threshold down towards a floor, and in a band between one and two times a bandwidth constant it ramps linearly. A prefetch presented on `pf_vld` is flagged for dropping when the MSHR occupancy has reached the threshold.

Top module: `llc_rate_throttle`

## Requirements
- R1: After reset the rate output equals BW (16 by default), the threshold equals 2, and no drop is signalled while occupancy is below 2.
- R2: On an access the interval is the cycle input minus the stored previous-access time, taken modulo 2^12, so the counter may wrap. The stored time is replaced by the cycle input only on an access.
- R3: On an access the signed 13-bit gauge becomes gauge + interval − rate, clamped to the range −4096..+4095.
- R4: On an access whose gauge result reaches +4095 the rate rises by one, and on one whose result reaches −4096 it falls by one. Otherwise the rate holds. The rate never changes in a cycle without an access.
- R5: The 8-bit rate saturates at 255 and at 0 and never wraps.
- R6: The threshold is a register updated every cycle from the current rate and best score. It equals 12 when the best score exceeds 20 or the rate exceeds 2×BW.
- R7: Otherwise the threshold is 2 when the rate is below BW. For BW ≤ rate ≤ 2×BW it is 2 + floor(10×(rate−BW)/BW), and the division is a right shift when BW is a power of two.
- R8: `pf_drop` is asserted in the same cycle exactly when `pf_vld` is high and `mshr_occ` ≥ the current threshold. It is never asserted without `pf_vld`.
- R9: A best score above 20 forces the threshold to 12 for every rate value, including rates of 0 and below BW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | One LLC access occurs this cycle |
| cyc_now | input | 12 | Low bits of the free-running cycle counter |
| best_score | input | 5 | Score of the current best offset |
| mshr_occ | input | 5 | Current number of busy MSHR entries |
| pf_vld | input | 1 | A prefetch request is waiting for a decision |
| rate_o | output | 8 | Current estimate of cycles between LLC accesses |
| thresh_o | output | 5 | Registered MSHR occupancy threshold |
| pf_drop | output | 1 | Drop the waiting prefetch request |

## Verification
The bench drives the rate through its whole range. It uses maximal intervals to climb to 255 and hold there, then zero intervals to descend to 0 and hold. A design that wrapped the rate would jump from 255 to 0 or from 0 to 255 there. Pseudo-random cycle values make the timestamp wrap many times, which catches an interval computed without modular arithmetic, since that would push the gauge the wrong way. At every step the threshold is compared against the piecewise formula for scores on both sides of 20. This exposes an off-by-one at BW or at 2×BW, a missing score override, and a wrong slope or shift. Occupancy sweeps around the threshold catch a drop compare that used > instead of ≥, or one that fired without a request.

// File: rtl/rate_thr_pkg.sv
package rate_thr_pkg;
  // Outcome of one gauge update.
  typedef enum logic [1:0] {
    GEV_NONE = 2'd0,
    GEV_UP   = 2'd1,
    GEV_DN   = 2'd2
  } gauge_ev_e;

  localparam int unsigned DEF_TS_W      = 12;
  localparam int unsigned DEF_GAUGE_W   = 13;
  localparam int unsigned DEF_RATE_W    = 8;
  localparam int unsigned DEF_SCORE_W   = 5;
  localparam int unsigned DEF_OCC_W     = 5;
  localparam int unsigned DEF_BW        = 16;
  localparam int unsigned DEF_LOW_SCORE = 20;
  localparam int unsigned DEF_THR_HI    = 12;
  localparam int unsigned DEF_THR_LO    = 2;
  localparam int unsigned DEF_THR_SPAN  = 10;
endpackage

// File: rtl/acc_interval.sv
module acc_interval #(
  parameter int unsigned TS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [TS_W-1:0] cyc_now,
  output logic [TS_W-1:0] dt_o
);
  logic [TS_W-1:0] prev_q;

  // Modular difference: wraparound of the stamp is absorbed by truncation.
  function automatic logic [TS_W-1:0] interval_of(input logic [TS_W-1:0] now,
                                                  input logic [TS_W-1:0] prev);
    return now - prev;
  endfunction

  assign dt_o = interval_of(cyc_now, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (fire) begin
      prev_q <= cyc_now;
    end
  end
endmodule

// File: rtl/gauge_rate.sv
module gauge_rate
  import rate_thr_pkg::*;
#(
  parameter int unsigned TS_W    = 12,
  parameter int unsigned GAUGE_W = 13,
  parameter int unsigned RATE_W  = 8,
  parameter int unsigned BW      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [TS_W-1:0]           dt,
  output logic [RATE_W-1:0]         rate_o,
  output logic signed [GAUGE_W-1:0] gauge_o,
  output logic                      at_hi,
  output logic                      at_lo
);
  localparam int unsigned SUM_W = GAUGE_W + 2;
  localparam logic signed [GAUGE_W-1:0] G_MAX = {1'b0, {(GAUGE_W-1){1'b1}}};
  localparam logic signed [GAUGE_W-1:0] G_MIN = {1'b1, {(GAUGE_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0]   S_MAX = {{2{1'b0}}, G_MAX};
  localparam logic signed [SUM_W-1:0]   S_MIN = {{2{1'b1}}, G_MIN};
  localparam logic [RATE_W-1:0]         R_MAX = {RATE_W{1'b1}};
  localparam logic [RATE_W-1:0]         R_RST = RATE_W'(BW);

  logic signed [GAUGE_W-1:0] gauge_q;
  logic [RATE_W-1:0]         rate_q;
  logic signed [SUM_W-1:0]   sum;
  logic signed [GAUGE_W-1:0] gauge_nx;
  gauge_ev_e                 ev;

  // Raw gauge step in a width that cannot overflow.
  function automatic logic signed [SUM_W-1:0] gauge_step(
      input logic signed [GAUGE_W-1:0] g,
      input logic [TS_W-1:0]           d,
      input logic [RATE_W-1:0]         r);
    logic signed [SUM_W-1:0] gs, ds, rs;
    gs = {{2{g[GAUGE_W-1]}}, g};
    ds = $signed({{(SUM_W-TS_W){1'b0}}, d});
    rs = $signed({{(SUM_W-RATE_W){1'b0}}, r});
    return gs + ds - rs;
  endfunction

  // Saturating rate move driven by the gauge outcome.
  function automatic logic [RATE_W-1:0] rate_move(input logic [RATE_W-1:0] r,
                                                  input gauge_ev_e e);
    logic [RATE_W-1:0] res;
    res = r;
    if (e == GEV_UP && r != R_MAX) res = r + RATE_W'(1);
    if (e == GEV_DN && r != '0)    res = r - RATE_W'(1);
    return res;
  endfunction

  always_comb begin
    sum = gauge_step(gauge_q, dt, rate_q);
    if (sum >= S_MAX) begin
      gauge_nx = G_MAX;
      ev       = GEV_UP;
    end else if (sum <= S_MIN) begin
      gauge_nx = G_MIN;
      ev       = GEV_DN;
    end else begin
      gauge_nx = sum[GAUGE_W-1:0];
      ev       = GEV_NONE;
    end
  end

  assign at_hi   = fire && (ev == GEV_UP);
  assign at_lo   = fire && (ev == GEV_DN);
  assign rate_o  = rate_q;
  assign gauge_o = gauge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gauge_q <= '0;
      rate_q  <= R_RST;
    end else if (fire) begin
      gauge_q <= gauge_nx;
      rate_q  <= rate_move(rate_q, ev);
    end
  end
endmodule

// File: rtl/thresh_calc.sv
module thresh_calc #(
  parameter int unsigned RATE_W    = 8,
  parameter int unsigned SCORE_W   = 5,
  parameter int unsigned OCC_W     = 5,
  parameter int unsigned BW        = 16,
  parameter int unsigned LOW_SCORE = 20,
  parameter int unsigned THR_HI    = 12,
  parameter int unsigned THR_LO    = 2,
  parameter int unsigned THR_SPAN  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATE_W-1:0]  rate,
  input  logic [SCORE_W-1:0] score,
  output logic [OCC_W-1:0]   thr_o
);
  localparam int unsigned   SPAN_W = $clog2(THR_SPAN + 1);
  localparam int unsigned   PROD_W = RATE_W + SPAN_W;
  localparam int unsigned   BW_SH  = $clog2(BW);
  localparam bit            BW_POW2 = ((1 << BW_SH) == BW);
  localparam logic [RATE_W:0]    BW_X  = (RATE_W+1)'(BW);
  localparam logic [RATE_W:0]    BW2_X = (RATE_W+1)'(2 * BW);
  localparam logic [SCORE_W-1:0] LOW_S = SCORE_W'(LOW_SCORE);
  localparam logic [OCC_W-1:0]   T_HI  = OCC_W'(THR_HI);
  localparam logic [OCC_W-1:0]   T_LO  = OCC_W'(THR_LO);
  localparam logic [PROD_W-1:0]  SPAN_P = PROD_W'(THR_SPAN);
  localparam logic [PROD_W-1:0]  BW_P   = PROD_W'(BW);

  logic [RATE_W:0]    rate_x;
  logic [PROD_W-1:0]  excess;
  logic [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]  frac;
  logic [OCC_W-1:0]   thr_nx;

  assign rate_x = {1'b0, rate};
  assign excess = (rate_x >= BW_X) ? PROD_W'(rate_x - BW_X) : '0;
  assign prod   = excess * SPAN_P;

  // Slope division: a shift for a power-of-two bandwidth constant, else a divider.
  generate
    if (BW_POW2) begin : g_shift
      assign frac = prod >> BW_SH;
    end else begin : g_div
      assign frac = prod / BW_P;
    end
  endgenerate

  function automatic logic [OCC_W-1:0] pick_thr(input logic [SCORE_W-1:0] s,
                                                input logic [RATE_W:0]    r,
                                                input logic [PROD_W-1:0]  f);
    if (s > LOW_S || r > BW2_X) return T_HI;
    if (r < BW_X)               return T_LO;
    return T_LO + OCC_W'(f);
  endfunction

  assign thr_nx = pick_thr(score, rate_x, frac);

  always_ff @(posedge clk) begin
    if (!rst_n) thr_o <= T_LO;
    else        thr_o <= thr_nx;
  end
endmodule

// File: rtl/llc_rate_throttle.sv
module llc_rate_throttle
  import rate_thr_pkg::*;
#(
  parameter int unsigned TS_W      = DEF_TS_W,
  parameter int unsigned GAUGE_W   = DEF_GAUGE_W,
  parameter int unsigned RATE_W    = DEF_RATE_W,
  parameter int unsigned SCORE_W   = DEF_SCORE_W,
  parameter int unsigned OCC_W     = DEF_OCC_W,
  parameter int unsigned BW        = DEF_BW,
  parameter int unsigned LOW_SCORE = DEF_LOW_SCORE,
  parameter int unsigned THR_HI    = DEF_THR_HI,
  parameter int unsigned THR_LO    = DEF_THR_LO,
  parameter int unsigned THR_SPAN  = DEF_THR_SPAN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_vld,
  input  logic [TS_W-1:0]    cyc_now,
  input  logic [SCORE_W-1:0] best_score,
  input  logic [OCC_W-1:0]   mshr_occ,
  input  logic               pf_vld,
  output logic [RATE_W-1:0]  rate_o,
  output logic [OCC_W-1:0]   thresh_o,
  output logic               pf_drop
);
  // Named internal events, brought out for the checker.
  logic [TS_W-1:0]           acc_dt;
  logic signed [GAUGE_W-1:0] gauge_val;
  logic                      gauge_at_hi;
  logic                      gauge_at_lo;
  logic                      occ_full;

  acc_interval #(.TS_W(TS_W)) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (acc_vld),
    .cyc_now (cyc_now),
    .dt_o    (acc_dt)
  );

  gauge_rate #(
    .TS_W(TS_W), .GAUGE_W(GAUGE_W), .RATE_W(RATE_W), .BW(BW)
  ) u_gauge (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (acc_vld),
    .dt      (acc_dt),
    .rate_o  (rate_o),
    .gauge_o (gauge_val),
    .at_hi   (gauge_at_hi),
    .at_lo   (gauge_at_lo)
  );

  thresh_calc #(
    .RATE_W(RATE_W), .SCORE_W(SCORE_W), .OCC_W(OCC_W), .BW(BW),
    .LOW_SCORE(LOW_SCORE), .THR_HI(THR_HI), .THR_LO(THR_LO), .THR_SPAN(THR_SPAN)
  ) u_thresh (
    .clk   (clk),
    .rst_n (rst_n),
    .rate  (rate_o),
    .score (best_score),
    .thr_o (thresh_o)
  );

  assign occ_full = (mshr_occ >= thresh_o);
  assign pf_drop  = pf_vld && occ_full;
endmodule

// File: rtl/rate_throttle_chk.sv
module rate_throttle_chk #(
  parameter int unsigned RATE_W    = 8,
  parameter int unsigned SCORE_W   = 5,
  parameter int unsigned OCC_W     = 5,
  parameter int unsigned LOW_SCORE = 20,
  parameter int unsigned THR_HI    = 12,
  parameter int unsigned THR_LO    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_vld,
  input logic               pf_vld,
  input logic [SCORE_W-1:0] best_score,
  input logic [RATE_W-1:0]  rate_o,
  input logic [OCC_W-1:0]   thresh_o,
  input logic               pf_drop,
  input logic               gauge_at_hi,
  input logic               gauge_at_lo
);
  localparam logic [RATE_W-1:0]  R_MAX = {RATE_W{1'b1}};
  localparam logic [SCORE_W-1:0] LOW_S = SCORE_W'(LOW_SCORE);
  localparam logic [OCC_W-1:0]   T_HI  = OCC_W'(THR_HI);
  localparam logic [OCC_W-1:0]   T_LO  = OCC_W'(THR_LO);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> $stable(rate_o));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (gauge_at_hi && rate_o != R_MAX) |=> rate_o == $past(rate_o) + RATE_W'(1));

  a_r4_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (gauge_at_lo && rate_o != '0) |=> rate_o == $past(rate_o) - RATE_W'(1));

  a_r3_one_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !(gauge_at_hi && gauge_at_lo));

  a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && rate_o == R_MAX) |=> rate_o != '0);

  a_r5_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && rate_o == '0) |=> rate_o != R_MAX);

  a_r9_score_force: assert property (@(posedge clk) disable iff (!rst_n)
    (best_score > LOW_S) |=> thresh_o == T_HI);

  a_r7_thr_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_o >= T_LO && thresh_o <= T_HI);

  a_r8_drop_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    pf_drop |-> pf_vld);
endmodule

bind llc_rate_throttle rate_throttle_chk #(
  .RATE_W(RATE_W), .SCORE_W(SCORE_W), .OCC_W(OCC_W),
  .LOW_SCORE(LOW_SCORE), .THR_HI(THR_HI), .THR_LO(THR_LO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_vld     (acc_vld),
  .pf_vld      (pf_vld),
  .best_score  (best_score),
  .rate_o      (rate_o),
  .thresh_o    (thresh_o),
  .pf_drop     (pf_drop),
  .gauge_at_hi (gauge_at_hi),
  .gauge_at_lo (gauge_at_lo)
);

// File: tb/llc_rate_throttle_tb.sv
`timescale 1ns/1ps
module llc_rate_throttle_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_vld = 1'b0;
  logic [11:0] cyc_now = '0;
  logic [4:0] best_score = '0;
  logic [4:0] mshr_occ = '0;
  logic       pf_vld = 1'b0;
  logic [7:0] rate_o;
  logic [4:0] thresh_o;
  logic       pf_drop;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int m_prev = 0;
  int m_gauge = 0;
  int m_rate = 16;
  int m_thr = 2;
  int lcg = 12345;

  always #2 clk = ~clk;

  llc_rate_throttle u_dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .cyc_now(cyc_now),
    .best_score(best_score), .mshr_occ(mshr_occ), .pf_vld(pf_vld),
    .rate_o(rate_o), .thresh_o(thresh_o), .pf_drop(pf_drop)
  );

  function automatic int exp_thr(input int r, input int s);
    if (s > 20 || r > 32) return 12;
    if (r < 16) return 2;
    return 2 + (10 * (r - 16)) / 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_access(input int c);
    int dt;
    dt = (c - m_prev) & 4095;
    m_prev = c;
    m_gauge = m_gauge + dt - m_rate;
    if (m_gauge >= 4095) begin
      m_gauge = 4095;
      if (m_rate < 255) m_rate++;
    end else if (m_gauge <= -4096) begin
      m_gauge = -4096;
      if (m_rate > 0) m_rate--;
    end
  endtask

  // One access, then an idle cycle so the threshold register catches up.
  task automatic do_access(input int c, input int s);
    @(negedge clk);
    acc_vld = 1'b1;
    cyc_now = 12'(c);
    best_score = 5'(s);
    @(negedge clk);
    acc_vld = 1'b0;
    model_access(c);
    m_thr = exp_thr(m_rate, s);
    @(negedge clk);
    check("R2/R3/R4/R5 rate", int'(rate_o), m_rate);
    check("R6/R7/R9 threshold", int'(thresh_o), m_thr);
  endtask

  task automatic drop_sweep();
    for (int o = 0; o < 32; o++) begin
      for (int v = 0; v < 2; v++) begin
        mshr_occ = 5'(o);
        pf_vld = v[0];
        #1;
        check("R8 drop", int'(pf_drop), (v == 1 && o >= m_thr) ? 1 : 0);
      end
    end
    pf_vld = 1'b0;
    mshr_occ = '0;
  endtask

  function automatic int score_pick(input int i);
    case (i % 6)
      0: return 0;
      1: return 5;
      2: return 20;
      3: return 21;
      4: return 31;
      default: return 3;
    endcase
  endfunction

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rate reset", int'(rate_o), 16);
    check("R1 thresh reset", int'(thresh_o), 2);
    pf_vld = 1'b1; mshr_occ = 5'd1; #1;
    check("R1 no drop below threshold", int'(pf_drop), 0);
    pf_vld = 1'b0; mshr_occ = '0;

    // Climb with maximal intervals into top saturation (R5).
    c = 0;
    for (int i = 0; i < 260; i++) begin
      c = (c + 4095) & 4095;
      do_access(c, score_pick(i));
      if (i % 40 == 0) drop_sweep();
    end
    check("R5 top saturation", int'(rate_o), 255);

    // Descend with zero intervals into bottom saturation (R5).
    for (int i = 0; i < 320; i++) begin
      do_access(c, score_pick(i));
      if (i % 50 == 7) drop_sweep();
    end
    check("R5 bottom saturation", int'(rate_o), 0);

    // R9: high score with rate 0.
    do_access(c, 25);
    check("R9 override at low rate", int'(thresh_o), 12);

    // Random stamps with frequent wraparound (R2).
    for (int i = 0; i < 700; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      c = (lcg >> 8) & 4095;
      do_access(c, score_pick(i));
      if (i % 70 == 3) drop_sweep();
    end

    // Explicit wrap: previous near the top of the stamp range.
    do_access(4000, 0);
    do_access(100, 0);
    do_access(4090, 0);
    do_access(5, 7);

    // R4: stamps move but no access, rate must hold.
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cyc_now = 12'(i * 211);
      @(negedge clk);
      check("R4 idle hold", int'(rate_o), m_rate);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule